// File: doc/BRIEF.md
# Stepped Automatic Gain Controller

This block steers the gain of one optical receive channel. It takes per-bit flags from a peak detector: the peak went over the upper threshold, the peak reached the lower threshold, and a transition was seen. It drives a thermometer-coded amplifier chain and a three-way front-end sense impedance select. All decisions are paced to a window of two bit periods. With Manchester data, such a window always contains a '1' peak, so each window gives a trustworthy verdict.

A new signal is found with a two-phase search. The coarse phase drops the sense impedance and adds 6 dB stages. The fine phase then backs off in single 3 dB steps until the peak is no longer over range. After that, the controller tracks the signal and moves at most one 3 dB step per window. If no transitions are seen for a programmable number of windows, the signal is taken as lost and the search starts again. A one-cycle strobe marks every change of the gain or impedance outputs, so trim values held downstream can be applied in the same cycle.

Top module: `agc_stepper`

## Requirements
- R1: After reset, imp_sel is 2 (highest impedance), all amplifier stages are off, tracking is 0 and gain_upd is 0.
- R2: The gain level L (0 to 11, gain 3·L dB) is output as stage6_en with its lowest floor(L/2) bits set and the rest clear, and stage3_en equal to bit 0 of L.
- R3: imp_sel encodes 0 = lowest, 1 = middle, 2 = highest sense impedance; the value 3 never appears.
- R4: A window is two bit_tick pulses, counted from reset. Flags are sampled only on bit_tick and ORed over the window, and the outputs change only after the second tick of a window.
- R5: Coarse phase: if the window is over range and L>0, L drops by 1 and the fine phase starts. If it is over range with L=0, imp_sel drops by 1, or tracking starts if imp_sel is already 0. If it is not over range, below the lower threshold and L<10, L rises by 2. Otherwise the fine phase starts with no change.
- R6: Fine phase: if the window is over range and L>0, L drops by 1 and the phase continues. Otherwise tracking starts with no output change.
- R7: Tracking: an over-range window lowers L by 1, saturating at 0. Otherwise, a window that does not reach the lower threshold raises L by 1, saturating at 11. Otherwise L holds. imp_sel never changes while tracking.
- R8: For a signal of constant strength, tracking is reached with at most 14 output changes.
- R9: In the fine or tracking phase, when the count of consecutive windows without a transition reaches a nonzero lost_windows, the controller returns to the coarse phase with imp_sel 2 and L 0. A lost_windows value of 0 disables this.
- R10: gain_upd is high for exactly the cycles in which stage6_en, stage3_en or imp_sel differ from their values in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit period; flags are valid with it |
| over_hi | input | 1 | Peak exceeded the upper (over-range) threshold this bit |
| above_lo | input | 1 | Peak reached the lower threshold this bit |
| edge_seen | input | 1 | A data transition occurred this bit |
| lost_windows | input | 4 | Number of transition-free windows that means the signal is lost; 0 disables |
| stage6_en | output | 5 | Thermometer enables of the 6 dB stages |
| stage3_en | output | 1 | Enable of the 3 dB stage |
| imp_sel | output | 2 | Sense impedance select |
| gain_upd | output | 1 | Pulse marking a change of gain or impedance outputs |
| tracking | output | 1 | High while in slew-limited tracking |

## Verification
The assertions take for granted that bit_tick is a single-cycle pulse, that ticks are spaced at least two clocks apart, and that the flags are meaningful only while bit_tick is high. The spacing rule counts ticks and not clocks, so it holds for any bit period. The bench drives every bit as a one-cycle tick followed by three idle cycles and sets the flags before each tick. It reproduces a received signal with an abstract level model: peak equals strength plus 3 dB per gain level plus 20 dB per impedance step, with thresholds at 50 and 60. Strengths are picked to cover each impedance and both gain limits.

// File: rtl/agc_stepper.sv
module agc_stepper #(
  parameter int N6     = 5,
  parameter int LOSS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              over_hi,
  input  logic              above_lo,
  input  logic              edge_seen,
  input  logic [LOSS_W-1:0] lost_windows,
  output logic [N6-1:0]     stage6_en,
  output logic              stage3_en,
  output logic [1:0]        imp_sel,
  output logic              gain_upd,
  output logic              tracking
);
  localparam int NLVL       = 2 * N6 + 2;
  localparam int LW         = $clog2(NLVL);
  localparam int LMAX       = NLVL - 1;
  localparam int COARSE_TOP = 2 * N6;

  typedef enum logic [1:0] {S_CRS, S_FINE, S_TRK} st_t;

  st_t             st, n_st;
  logic [LW-1:0]   lvl, n_lvl;
  logic [1:0]      imp, n_imp;
  logic            ph, acc_over, acc_lo, acc_edge;
  logic [LOSS_W-1:0] lost_cnt;
  logic            eval, w_over, w_lo, w_edge, lost_hit;

  assign eval   = bit_tick & ph;
  assign w_over = acc_over | over_hi;
  assign w_lo   = acc_lo | above_lo;
  assign w_edge = acc_edge | edge_seen;

  assign lost_hit = eval && !w_edge && (st != S_CRS) && (lost_windows != '0) &&
                    (({1'b0, lost_cnt} + 1'b1) >= {1'b0, lost_windows});

  always_comb begin
    n_st  = st;
    n_lvl = lvl;
    n_imp = imp;
    if (eval) begin
      if (lost_hit) begin
        n_st  = S_CRS;
        n_lvl = '0;
        n_imp = 2'd2;
      end else begin
        case (st)
          S_CRS: begin
            if (w_over) begin
              if (lvl != '0) begin
                n_lvl = lvl - 1'b1;
                n_st  = S_FINE;
              end else if (imp != 2'd0) begin
                n_imp = imp - 1'b1;
              end else begin
                n_st = S_TRK;
              end
            end else if (!w_lo && lvl < LW'(COARSE_TOP)) begin
              n_lvl = lvl + LW'(2);
            end else begin
              n_st = S_FINE;
            end
          end
          S_FINE: begin
            if (w_over && lvl != '0) n_lvl = lvl - 1'b1;
            else                     n_st  = S_TRK;
          end
          default: begin
            if (w_over) begin
              if (lvl != '0) n_lvl = lvl - 1'b1;
            end else if (!w_lo && lvl != LW'(LMAX)) begin
              n_lvl = lvl + 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_CRS;
      lvl      <= '0;
      imp      <= 2'd2;
      ph       <= 1'b0;
      acc_over <= 1'b0;
      acc_lo   <= 1'b0;
      acc_edge <= 1'b0;
      lost_cnt <= '0;
      gain_upd <= 1'b0;
    end else begin
      st       <= n_st;
      lvl      <= n_lvl;
      imp      <= n_imp;
      gain_upd <= (n_lvl != lvl) || (n_imp != imp);
      if (bit_tick) begin
        ph <= ~ph;
        if (ph) begin
          acc_over <= 1'b0;
          acc_lo   <= 1'b0;
          acc_edge <= 1'b0;
          if (w_edge || lost_hit) lost_cnt <= '0;
          else if (lost_cnt != '1) lost_cnt <= lost_cnt + 1'b1;
        end else begin
          acc_over <= over_hi;
          acc_lo   <= above_lo;
          acc_edge <= edge_seen;
        end
      end
    end
  end

  for (genvar i = 0; i < N6; i++) begin : g_therm
    assign stage6_en[i] = (lvl[LW-1:1] > (LW-1)'(i));
  end
  assign stage3_en = lvl[0];
  assign imp_sel   = imp;
  assign tracking  = (st == S_TRK);
endmodule

// File: rtl/agc_stepper_chk.sv
module agc_stepper_chk #(
  parameter int N6 = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_tick,
  input logic [N6-1:0] stage6_en,
  input logic          stage3_en,
  input logic [1:0]    imp_sel,
  input logic          gain_upd,
  input logic          tracking
);
  int         lv;
  logic [1:0] ticks;

  assign lv = 2 * $countones(stage6_en) + int'(stage3_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ticks <= 2'd0;
    else if (gain_upd) ticks <= bit_tick ? 2'd1 : 2'd0;
    else if (bit_tick && ticks != 2'd3) ticks <= ticks + 2'd1;
  end

  p_therm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stage6_en & (stage6_en + 1'b1)) == '0);

  p_imp_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    imp_sel != 2'd3);

  p_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gain_upd |-> ticks >= 2'd2);

  p_slew_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tracking && $past(tracking) && gain_upd) |->
      ((lv == $past(lv) + 1 || lv + 1 == $past(lv)) && $stable(imp_sel)));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tracking) |-> (imp_sel == 2'd2 && lv == 0));

  p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_upd |-> ($stable(stage6_en) && $stable(stage3_en) && $stable(imp_sel)));
endmodule

bind agc_stepper agc_stepper_chk #(.N6(N6)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .stage6_en(stage6_en),
  .stage3_en(stage3_en), .imp_sel(imp_sel), .gain_upd(gain_upd), .tracking(tracking)
);

// File: tb/agc_stepper_tb.sv
module agc_stepper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  localparam int VS  [NV] = '{5, -20, -40, 30, 15, 50, 80, 25, 38};
  localparam int VLV [NV] = '{2,  10,  11,  0,  0,  0,  0,  2,  0};
  localparam int VIMP[NV] = '{2,   2,   2,  1,  2,  0,  0,  1,  1};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0, over_hi = 1'b0, above_lo = 1'b0, edge_seen = 1'b0;
  logic [3:0] lost_windows = 4'd0;
  logic [4:0] stage6_en;
  logic       stage3_en, gain_upd, tracking;
  logic [1:0] imp_sel;

  int n_tests = 0, n_fail = 0, upd_cnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agc_stepper u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .over_hi(over_hi),
    .above_lo(above_lo), .edge_seen(edge_seen), .lost_windows(lost_windows),
    .stage6_en(stage6_en), .stage3_en(stage3_en), .imp_sel(imp_sel),
    .gain_upd(gain_upd), .tracking(tracking)
  );

  always @(negedge clk) if (rst_n && gain_upd) upd_cnt++;

  function automatic int cur_lvl();
    return 2 * $countones(stage6_en) + int'(stage3_en);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bitp(input logic ov, input logic lo, input logic ed);
    over_hi = ov; above_lo = lo; edge_seen = ed;
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0; over_hi = 1'b0; above_lo = 1'b0; edge_seen = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic win(input logic ov, input logic lo, input logic ed);
    bitp(ov, lo, ed);
    bitp(ov, lo, ed);
  endtask

  task automatic model_bit(input int s);
    int pk;
    pk = s + 3 * cur_lvl() + 20 * int'(imp_sel);
    bitp(pk > 60, pk >= 50, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    // R1 reset state
    do_reset();
    check("R1 imp", int'(imp_sel), 2);
    check("R1 level", cur_lvl(), 0);
    check("R1 tracking", int'(tracking), 0);
    check("R1 strobe", int'(gain_upd), 0);

    // R8 R5 R6 R7 R3 R2: level model sweep
    for (int v = 0; v < NV; v++) begin
      do_reset();
      base = upd_cnt;
      for (int w = 0; w < 20; w++) begin
        model_bit(VS[v]);
        model_bit(VS[v]);
        if (w == 15) check("R8 steps to settle", int'(upd_cnt - base <= 14), 1);
      end
      check("R7 final level", cur_lvl(), VLV[v]);
      check("R3 final impedance", int'(imp_sel), VIMP[v]);
      check("R8 tracking reached", int'(tracking), 1);
    end

    // R4: flag from first tick counts, no change mid-window
    do_reset();
    base = upd_cnt;
    bitp(1'b1, 1'b1, 1'b1);
    check("R4 no mid-window change", int'(imp_sel), 2);
    check("R4 no mid-window strobe", upd_cnt - base, 0);
    bitp(1'b0, 1'b1, 1'b1);
    check("R4 ORed over flag", int'(imp_sel), 1);
    check("R10 strobe count", upd_cnt - base, 1);

    // R5 R6 R2: coarse raise, overshoot, fine descent
    do_reset();
    win(1'b0, 1'b0, 1'b1);
    check("R5 coarse raise", cur_lvl(), 2);
    check("R2 therm bits", int'(stage6_en), 1);
    win(1'b1, 1'b1, 1'b1);
    check("R5 overshoot drop", cur_lvl(), 1);
    check("R2 half stage", int'(stage3_en), 1);
    check("R5 fine phase", int'(tracking), 0);
    win(1'b1, 1'b1, 1'b1);
    check("R6 fine drop", cur_lvl(), 0);
    check("R6 still fine", int'(tracking), 0);
    base = upd_cnt;
    win(1'b0, 1'b1, 1'b1);
    check("R6 enter tracking", int'(tracking), 1);
    check("R6 no change on entry", upd_cnt - base, 0);

    // R7 R10 tracking rules
    win(1'b0, 1'b1, 1'b1);
    check("R10 hold no strobe", upd_cnt - base, 0);
    check("R7 hold", cur_lvl(), 0);
    win(1'b0, 1'b0, 1'b1);
    check("R7 raise", cur_lvl(), 1);
    check("R10 raise strobe", upd_cnt - base, 1);
    win(1'b1, 1'b1, 1'b1);
    check("R7 lower", cur_lvl(), 0);
    win(1'b1, 1'b1, 1'b1);
    check("R7 clamp low", cur_lvl(), 0);
    check("R7 impedance kept", int'(imp_sel), 2);

    // R9 signal loss restart
    win(1'b0, 1'b0, 1'b1);
    check("R7 raise before loss", cur_lvl(), 1);
    lost_windows = 4'd3;
    win(1'b0, 1'b1, 1'b0);
    win(1'b0, 1'b1, 1'b0);
    check("R9 not yet lost", int'(tracking), 1);
    check("R9 level kept", cur_lvl(), 1);
    win(1'b0, 1'b1, 1'b0);
    check("R9 back to search", int'(tracking), 0);
    check("R9 level reset", cur_lvl(), 0);
    check("R9 impedance reset", int'(imp_sel), 2);

    // R9 disabled when zero
    lost_windows = 4'd0;
    do_reset();
    win(1'b0, 1'b1, 1'b1);
    win(1'b0, 1'b1, 1'b1);
    check("R9 tracking before idle", int'(tracking), 1);
    for (int w = 0; w < 6; w++) win(1'b0, 1'b1, 1'b0);
    check("R9 zero disables loss", int'(tracking), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule